// File: doc/BRIEF.md
# USB Link Status LED Controller

This block turns a handful of USB device status events into the timing of one indicator LED. Before the device is configured, the LED rests dark and flashes on briefly for each item of bus traffic seen during enumeration. Once the host has configured the device, the LED rests lit and dips dark briefly for every transfer that finishes with an acknowledge handshake. While the device is suspended, the LED is dark whatever else happens. The block does not decode USB itself. Other logic supplies the event pulses and the level flags, and this block only shapes the light.

Each flash or dip lasts a parameterised number of ticks (`PULSE_TICKS`, default 4096). A tick is a single-cycle enable taken from a slower system timebase. A new qualifying event during a flash restarts the full length. A change of operating mode cancels any flash in progress. The mode changes when the device enters or leaves suspend, or when the configured flag rises or falls. The LED pin is driven from a flop, so it cannot glitch. No pin carries a data stream, so all ports are plain level or pulse signals with no handshake.

Top module: `usb_link_led`

## Requirements
- R1: While `rst_i` is high at a clock edge, the LED is dark after that edge and the flash timer is cleared. The block then starts in the unconfigured mode.
- R2: While not suspended and not configured, the LED is dark at rest. A high `bus_act_i` at an edge lights the LED from that edge. It stays lit until `PULSE_TICKS` ticks have been counted on later edges, then goes dark.
- R3: While not suspended and configured, with no flash running, the LED is lit.
- R4: While configured and not suspended, `xfer_done_i` and `xfer_ack_i` both high at an edge darken the LED from that edge for `PULSE_TICKS` ticks. The LED is lit again afterwards.
- R5: An event that does not belong to the current mode leaves the LED and timer untouched. This covers `xfer_done_i` with `xfer_ack_i` low, `bus_act_i` while configured, and any transfer while unconfigured.
- R6: `suspend_i` high at an edge makes the LED dark after that edge. It also clears the timer, and all events are ignored.
- R7: At the first edge with `suspend_i` low after a suspended edge, the LED takes its resting level: lit if `configured_i` is high, dark if low.
- R8: When `configured_i` changes, the next edge applies the new mode's resting level and cancels any running flash. The only exception is a qualifying event of the new mode on that same edge.
- R9: A qualifying event while a flash is running restarts the count at the full `PULSE_TICKS`. The timer never holds more than `PULSE_TICKS`.
- R10: The flash timer decrements only on edges where `tick_i` is high. Edges without a tick leave the flash length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Single-cycle timebase enable that advances the flash timer |
| bus_act_i | input | 1 | Pulse per item of enumeration traffic |
| configured_i | input | 1 | Level, high once the device is configured |
| xfer_done_i | input | 1 | Pulse when a transfer completes |
| xfer_ack_i | input | 1 | Qualifies `xfer_done_i`: high if the transfer ended with an acknowledge |
| suspend_i | input | 1 | Level, high while the device is suspended |
| led_o | output | 1 | Registered LED drive, 1 = lit |

## Verification
Every input sampled at a rising edge shows on `led_o` right after that same edge, since the only register on the path is the output flop. The bench therefore drives inputs just after a falling edge. It predicts the LED level for the coming rising edge with its own model of the tick count and mode, and compares at the following falling edge. A flash started at edge k with a tick on every edge stays visible for exactly `PULSE_TICKS` cycles. With sparse ticks it stretches by the tick-free edges, and the checks track that edge by edge. The mode-change edges are the first edge out of suspend and the edge where the configured flag flips. Each is checked at the edge itself rather than after a settling delay.

// File: rtl/usbled_pkg.sv
package usbled_pkg;

  // Operating mode of the indicator, chosen from the level flags.
  typedef enum logic [1:0] {
    LM_ENUM  = 2'd0,  // not configured: dark baseline, flash on traffic
    LM_RUN   = 2'd1,  // configured: lit baseline, dip on acked transfer
    LM_SLEEP = 2'd2   // suspended: always dark
  } led_mode_e;

  function automatic led_mode_e pick_mode(input logic susp, input logic cfg);
    if (susp)     return LM_SLEEP;
    else if (cfg) return LM_RUN;
    else          return LM_ENUM;
  endfunction

  // LED level for a mode given whether a flash is running.
  function automatic logic led_level(input led_mode_e mode, input logic flash);
    case (mode)
      LM_ENUM: return flash;
      LM_RUN:  return ~flash;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/usbled_mode_sel.sv
module usbled_mode_sel
  import usbled_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      suspend_i,
  input  logic      configured_i,
  input  logic      bus_act_i,
  input  logic      xfer_done_i,
  input  logic      xfer_ack_i,
  output led_mode_e mode_o,
  output logic      trigger_o,
  output logic      clear_o
);

  led_mode_e mode_q;
  logic      ack_evt;

  assign mode_o  = pick_mode(suspend_i, configured_i);
  assign ack_evt = xfer_done_i & xfer_ack_i;

  // Only the event type that belongs to the present mode starts a flash.
  always_comb begin
    case (mode_o)
      LM_ENUM: trigger_o = bus_act_i;
      LM_RUN:  trigger_o = ack_evt;
      default: trigger_o = 1'b0;
    endcase
  end

  // A mode change, or being asleep, cancels any running flash.
  assign clear_o = (mode_o != mode_q) | (mode_o == LM_SLEEP);

  always_ff @(posedge clk_i) begin
    if (rst_i) mode_q <= LM_ENUM;
    else       mode_q <= mode_o;
  end

endmodule

// File: rtl/usbled_blink_timer.sv
module usbled_blink_timer #(
  parameter int PULSE_TICKS = 4096,
  parameter int CW          = $clog2(PULSE_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic          trigger_i,
  input  logic          clear_i,
  output logic [CW-1:0] count_o,
  output logic          active_next_o
);

  localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Load wins over clear so an event of the new mode is honoured on the
  // very edge that the mode changes.
  always_comb begin
    cnt_d = cnt_q;
    if (trigger_i)                      cnt_d = LOAD;
    else if (clear_i)                   cnt_d = '0;
    else if (tick_i && (cnt_q != '0))   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_d;
  end

  assign count_o       = cnt_q;
  assign active_next_o = (cnt_d != '0);

endmodule

// File: rtl/usbled_drive.sv
module usbled_drive
  import usbled_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  led_mode_e mode_i,
  input  logic      flash_i,
  output logic      led_o
);

  logic led_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) led_q <= 1'b0;
    else       led_q <= led_level(mode_i, flash_i);
  end

  assign led_o = led_q;

endmodule

// File: rtl/usb_link_led.sv
module usb_link_led
  import usbled_pkg::*;
#(
  parameter int PULSE_TICKS = 4096
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic bus_act_i,
  input  logic configured_i,
  input  logic xfer_done_i,
  input  logic xfer_ack_i,
  input  logic suspend_i,
  output logic led_o
);

  localparam int CW = $clog2(PULSE_TICKS + 1);

  led_mode_e     mode;
  logic          trigger;
  logic          clear;
  logic [CW-1:0] flash_count;
  logic          flash_next;

  usbled_mode_sel u_mode (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .suspend_i    (suspend_i),
    .configured_i (configured_i),
    .bus_act_i    (bus_act_i),
    .xfer_done_i  (xfer_done_i),
    .xfer_ack_i   (xfer_ack_i),
    .mode_o       (mode),
    .trigger_o    (trigger),
    .clear_o      (clear)
  );

  usbled_blink_timer #(
    .PULSE_TICKS (PULSE_TICKS),
    .CW          (CW)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .tick_i        (tick_i),
    .trigger_i     (trigger),
    .clear_i       (clear),
    .count_o       (flash_count),
    .active_next_o (flash_next)
  );

  usbled_drive u_drive (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .mode_i  (mode),
    .flash_i (flash_next),
    .led_o   (led_o)
  );

endmodule

// File: rtl/usb_link_led_chk.sv
module usb_link_led_chk #(
  parameter int PULSE_TICKS = 4096,
  parameter int CW          = $clog2(PULSE_TICKS + 1)
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          tick_i,
  input logic          bus_act_i,
  input logic          configured_i,
  input logic          xfer_done_i,
  input logic          xfer_ack_i,
  input logic          suspend_i,
  input logic          led_o,
  input logic [CW-1:0] count
);

  assert_reset_dark_R1: assert property (@(posedge clk_i)
    rst_i |=> (!led_o && count == '0));

  assert_enum_flash_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!suspend_i && !configured_i && bus_act_i) |=> led_o);

  assert_enum_rest_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!suspend_i && !configured_i && !bus_act_i && count == '0) |=> !led_o);

  // R3 and R5: with no flash running, a non-acked or foreign event keeps the lit baseline.
  assert_run_rest_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!suspend_i && configured_i && !(xfer_done_i && xfer_ack_i) && count == '0) |=> led_o);

  assert_ack_dip_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!suspend_i && configured_i && xfer_done_i && xfer_ack_i) |=> !led_o);

  assert_sleep_dark_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    suspend_i |=> (!led_o && count == '0));

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    count <= CW'(PULSE_TICKS));

  assert_tick_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && count != '0) |=>
      (count == $past(count) || count == CW'(PULSE_TICKS) || count == '0));

endmodule

bind usb_link_led usb_link_led_chk #(
  .PULSE_TICKS (PULSE_TICKS),
  .CW          (CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .tick_i       (tick_i),
  .bus_act_i    (bus_act_i),
  .configured_i (configured_i),
  .xfer_done_i  (xfer_done_i),
  .xfer_ack_i   (xfer_ack_i),
  .suspend_i    (suspend_i),
  .led_o        (led_o),
  .count        (flash_count)
);

// File: tb/usb_link_led_tb_top.sv
`timescale 1ns/1ps
module usb_link_led_tb_top;

  localparam int P = 8;

  logic clk = 1'b0;
  logic rst, tick, bus_act, configured, xfer_done, xfer_ack, suspend;
  logic led;

  int checks = 0;
  int fails  = 0;

  // Reference model state (mode: 0 unconfigured, 1 configured, 2 suspended)
  int    m_cnt   = 0;
  int    m_modeq = 0;
  bit    exp_led = 1'b0;
  string exp_tag = "R1";
  bit    armed   = 1'b0;

  always #2.5 clk = ~clk;

  usb_link_led #(.PULSE_TICKS(P)) dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .tick_i       (tick),
    .bus_act_i    (bus_act),
    .configured_i (configured),
    .xfer_done_i  (xfer_done),
    .xfer_ack_i   (xfer_ack),
    .suspend_i    (suspend),
    .led_o        (led)
  );

  function automatic int mode_of(bit s, bit c);
    return s ? 2 : (c ? 1 : 0);
  endfunction

  function automatic bit level_of(int mode, int cnt);
    if (mode == 2) return 1'b0;
    if (mode == 1) return (cnt == 0);
    return (cnt != 0);
  endfunction

  // Apply one cycle of inputs; check the previous prediction first.
  task automatic cyc(bit r, bit t, bit b, bit c, bit xd, bit xa, bit s);
    int  mode;
    bit  chg, evt;
    @(negedge clk);
    if (armed) begin
      checks++;
      if (led !== exp_led) begin
        fails++;
        $display("FAIL %s: led actual=%0b expected=%0b at %0t", exp_tag, led, exp_led, $time);
      end
    end
    armed = 1'b1;
    rst = r; tick = t; bus_act = b; configured = c;
    xfer_done = xd; xfer_ack = xa; suspend = s;
    if (r) begin
      m_cnt = 0; m_modeq = 0; exp_led = 1'b0; exp_tag = "R1";
    end else begin
      mode = mode_of(s, c);
      chg  = (mode != m_modeq);
      evt  = (mode == 0) ? b : ((mode == 1) ? (xd && xa) : 1'b0);
      if (mode == 2)                      exp_tag = "R6";
      else if (chg && m_modeq == 2)       exp_tag = "R7";
      else if (chg)                       exp_tag = "R8";
      else if (evt && m_cnt > 0)          exp_tag = "R9";
      else if (evt && mode == 1)          exp_tag = "R4";
      else if (evt)                       exp_tag = "R2";
      else if (xd || (mode == 1 && b))    exp_tag = "R5";
      else if (!t && m_cnt > 0)           exp_tag = "R10";
      else if (mode == 1)                 exp_tag = "R3";
      else                                exp_tag = "R2";
      if (evt)                       m_cnt = P;
      else if (chg || mode == 2)     m_cnt = 0;
      else if (t && m_cnt > 0)       m_cnt = m_cnt - 1;
      exp_led = level_of(mode, m_cnt);
      m_modeq = mode;
    end
  endtask

  task automatic idle(int n, bit c, bit s, bit t);
    for (int i = 0; i < n; i++) cyc(1'b0, t, 1'b0, c, 1'b0, 1'b0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles actual=200000 expected fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A5E_D00D));
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    idle(2, 1'b0, 1'b0, 1'b1);
    // R2: single traffic flash, exact length with a tick every edge
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(P + 3, 1'b0, 1'b0, 1'b1);
    // R9: retrigger mid-flash
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(P / 2, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(P + 2, 1'b0, 1'b0, 1'b1);
    // R10: no ticks holds the flash
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(P + 4, 1'b0, 1'b0, 1'b0);
    idle(P + 2, 1'b0, 1'b0, 1'b1);
    // R5: transfers ignored while unconfigured
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(2, 1'b0, 1'b0, 1'b1);
    // R3: configure
    idle(4, 1'b1, 1'b0, 1'b1);
    // R4: acked transfer dip
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    idle(P + 2, 1'b1, 1'b0, 1'b1);
    // R5: non-acked transfer and bus traffic while configured
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(2, 1'b1, 1'b0, 1'b1);
    // R8: configured drops mid-dip, then rises mid-flash
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    idle(2, 1'b1, 1'b0, 1'b1);
    idle(2, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(3, 1'b1, 1'b0, 1'b1);
    // R6: suspend with events present
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    // R7: leave suspend unconfigured, then configured
    idle(2, 1'b0, 1'b0, 1'b1);
    idle(2, 1'b1, 1'b1, 1'b1);
    idle(3, 1'b1, 1'b0, 1'b1);
    // R1: reset in the middle of a dip
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(2, 1'b1, 1'b0, 1'b1);
    // Constrained random mix
    begin
      bit c = 1'b0, s = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 60 == 0) c = ~c;
        if ($urandom % 90 == 0) s = ~s;
        cyc(($urandom % 1500) == 0, ($urandom % 4) != 0,
            ($urandom % 10) == 0, c, ($urandom % 8) == 0,
            ($urandom % 10) < 7, s);
      end
    end
    idle(1, 1'b0, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule